// File: doc/BRIEF.md
# Output short-detect and disable controller

This block guards a set of high-current outputs driven by three complementary output pairs. It raises a short flag whenever both signals of any pair are low together, provided short comparison is enabled. It also watches an active-low emergency-disable pin and latches a disable request when that pin sees a falling edge, or a run of low samples taken at a divided clock, depending on the selected mode. While either flag is set, all six high-current outputs are forced to high impedance. Software clears each flag through a read-then-write-zero sequence on one 16-bit control/status register.

The pin filter is a three-state machine. `FLT_WAIT_LOW` waits for a low sample on a sample tick and moves to `FLT_COUNT`. From `FLT_COUNT`, a high sample returns it to `FLT_WAIT_LOW`. The sixteenth consecutive low sample moves it to `FLT_HELD` and issues the request. `FLT_HELD` returns to `FLT_WAIT_LOW` on the first high sample. In edge mode the machine is held in `FLT_WAIT_LOW` and a falling edge of the synchronised pin issues the request. Before either detection mode sees the pin, it passes through two flip-flops that reset to 1.

Register layout:
- bit 15: short flag.
- bits 14:10 and 6:2: read 0.
- bit 9: compare enable.
- bit 8: interrupt enable.
- bit 7: disable flag.
- bits 1:0: pin mode.

Top module: `outguard_ctl`

## Requirements
- R1: After reset every register bit reads 0, `hiz_en` is 0 and `irq` is 0.
- R2: With compare enable (bit 9) set, the short flag (bit 15) reads 1 one clock after `phase_in[2k]` and `phase_in[2k+1]` are both low for any k in 0..2.
- R3: With compare enable clear, a both-low pair leaves the short flag at 0.
- R4: The short flag clears only on a write with bit 15 = 0 that follows a read taken while the flag was 1. Two writes have no effect on it: a write of 0 without such a read, and a write of 1.
- R5: If a short is present in the same cycle as a valid clearing write, the flag stays 1.
- R6: Bits 14:10 and 6:2 always read 0. Writing 1 to bit 15 or bit 7 never sets them. Bits 9, 8 and 1:0 read back what was written.
- R7: `hiz_en` is all ones while the short flag or the disable flag is 1, and all zeros otherwise.
- R8: `irq` equals interrupt enable (bit 8) AND the short flag.
- R9: In pin mode 00, a falling edge on `dis_pin_n` sets the disable flag (bit 7), visible three clocks after the pin changes.
- R10: In modes 01, 10 and 11 the pin is sampled every 8, 16 and 128 clocks respectively. Sixteen consecutive low samples set the disable flag, and a high sample restarts the count.
- R11: The disable flag clears only on a write with bit 7 = 0 that follows a read taken while it was 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Register contents |
| phase_in | input | 6 | Monitored outputs, pair k on bits 2k and 2k+1 |
| dis_pin_n | input | 1 | Active-low emergency-disable pin |
| hiz_en | output | 6 | Per-pin high-impedance force |
| irq | output | 1 | Short interrupt request |

## Verification
A wrong flag or arm bit shows up on `reg_rdata`, `hiz_en` and `irq` one clock after the wrong transition, so a per-clock reference model catches it at once. A filter count or prescaler error is hidden until it changes the disable flag, which can be up to 16 sample periods (2048 clocks in the slowest mode) after the cause. Pulses of 15 samples sit just under the threshold and catch off-by-one counts, and a high sample inside a run catches a missing restart.

// File: rtl/og_pkg.sv
package og_pkg;
    typedef enum logic [1:0] {
        PIN_EDGE   = 2'b00,
        PIN_DIV8   = 2'b01,
        PIN_DIV16  = 2'b10,
        PIN_DIV128 = 2'b11
    } pin_mode_e;

    typedef enum logic [1:0] {
        FLT_WAIT_LOW = 2'b00,
        FLT_COUNT    = 2'b01,
        FLT_HELD     = 2'b10
    } flt_state_e;

    localparam int DIV8_LOG   = 3;
    localparam int DIV16_LOG  = 4;
    localparam int DIV128_LOG = 7;

    localparam int BIT_SHORT = 15;
    localparam int BIT_CMP   = 9;
    localparam int BIT_IEN   = 8;
    localparam int BIT_DIS   = 7;
endpackage

// File: rtl/og_sync2.sv
module og_sync2 #(
    parameter int  W        = 1,
    parameter logic RST_VAL = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] s1_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_q <= {W{RST_VAL}};
            q    <= {W{RST_VAL}};
        end else begin
            s1_q <= d;
            q    <= s1_q;
        end
    end
endmodule

// File: rtl/og_short_det.sv
module og_short_det #(
    parameter int NPAIR = 3
) (
    input  logic [2*NPAIR-1:0] phase,
    input  logic               en,
    output logic               hit
);
    logic [NPAIR-1:0] pair_low;

    for (genvar k = 0; k < NPAIR; k++) begin : g_pair
        assign pair_low[k] = ~phase[2*k] & ~phase[2*k+1];
    end

    assign hit = en & (|pair_low);
endmodule

// File: rtl/og_pin_filter.sv
module og_pin_filter
    import og_pkg::*;
#(
    parameter int NSAMP = 16,
    parameter int PRE_W = DIV128_LOG
) (
    input  logic      clk,
    input  logic      rst_n,
    input  pin_mode_e mode,
    input  logic      pin_s,
    output logic      req
);
    localparam int CNT_W = $clog2(NSAMP);

    logic [PRE_W-1:0] pre_q;
    logic             prev_q;
    logic             tick;
    flt_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             lvl_req;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q  <= '0;
            prev_q <= 1'b1;
        end else begin
            pre_q  <= pre_q + 1'b1;
            prev_q <= pin_s;
        end
    end

    always_comb begin
        unique case (mode)
            PIN_DIV8:   tick = &pre_q[DIV8_LOG-1:0];
            PIN_DIV16:  tick = &pre_q[DIV16_LOG-1:0];
            PIN_DIV128: tick = &pre_q[DIV128_LOG-1:0];
            default:    tick = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= FLT_WAIT_LOW;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        lvl_req = 1'b0;
        if (mode == PIN_EDGE) begin
            state_d = FLT_WAIT_LOW;
            cnt_d   = '0;
        end else if (tick) begin
            unique case (state_q)
                FLT_WAIT_LOW: begin
                    if (!pin_s) begin
                        state_d = FLT_COUNT;
                        cnt_d   = CNT_W'(1);
                    end
                end
                FLT_COUNT: begin
                    if (pin_s) begin
                        state_d = FLT_WAIT_LOW;
                        cnt_d   = '0;
                    end else if (cnt_q == CNT_W'(NSAMP - 1)) begin
                        state_d = FLT_HELD;
                        cnt_d   = '0;
                        lvl_req = 1'b1;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
                FLT_HELD: begin
                    if (pin_s) state_d = FLT_WAIT_LOW;
                end
                default: state_d = FLT_WAIT_LOW;
            endcase
        end
    end

    assign req = (mode == PIN_EDGE) ? (prev_q & ~pin_s) : lvl_req;

    // R10: a high sample in any sampled mode restarts the run
    a_r10_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != PIN_EDGE && tick && pin_s) |=> state_q == FLT_WAIT_LOW);

    // R10: counting state never holds an empty count
    a_r10_cnt_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == FLT_COUNT) |-> cnt_q != '0);
endmodule

// File: rtl/og_ctrl_regs.sv
module og_ctrl_regs
    import og_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr,
    input  logic        rd,
    input  logic [15:0] wdata,
    input  logic        short_hit,
    input  logic        pin_req,
    output logic [15:0] rdata,
    output pin_mode_e   mode,
    output logic        cmp_en,
    output logic        irq_en,
    output logic        short_q,
    output logic        dis_q
);
    logic short_arm_q, dis_arm_q;
    logic short_clr, dis_clr;

    assign short_clr = wr & short_arm_q & ~wdata[BIT_SHORT];
    assign dis_clr   = wr & dis_arm_q   & ~wdata[BIT_DIS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode        <= PIN_EDGE;
            cmp_en      <= 1'b0;
            irq_en      <= 1'b0;
            short_q     <= 1'b0;
            dis_q       <= 1'b0;
            short_arm_q <= 1'b0;
            dis_arm_q   <= 1'b0;
        end else begin
            short_q <= short_hit | (short_q & ~short_clr);
            dis_q   <= pin_req   | (dis_q & ~dis_clr);
            if (wr) begin
                mode        <= pin_mode_e'(wdata[1:0]);
                cmp_en      <= wdata[BIT_CMP];
                irq_en      <= wdata[BIT_IEN];
                short_arm_q <= 1'b0;
                dis_arm_q   <= 1'b0;
            end else if (rd) begin
                if (short_q) short_arm_q <= 1'b1;
                if (dis_q)   dis_arm_q   <= 1'b1;
            end
        end
    end

    always_comb begin
        rdata            = '0;
        rdata[BIT_SHORT] = short_q;
        rdata[BIT_CMP]   = cmp_en;
        rdata[BIT_IEN]   = irq_en;
        rdata[BIT_DIS]   = dis_q;
        rdata[1:0]       = mode;
    end

    a_r2_set_seen: assert property (@(posedge clk) disable iff (!rst_n)
        short_hit |=> short_q);

    a_r3_cmp_off: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmp_en && !short_q) |=> !short_q);

    a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (short_q && !wr) |=> short_q);

    a_r11_dis_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (dis_q && !wr) |=> dis_q);
endmodule

// File: rtl/outguard_ctl.sv
module outguard_ctl
    import og_pkg::*;
#(
    parameter int NPAIR = 3,
    parameter int NSAMP = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_wr,
    input  logic                reg_rd,
    input  logic [15:0]         reg_wdata,
    output logic [15:0]         reg_rdata,
    input  logic [2*NPAIR-1:0]  phase_in,
    input  logic                dis_pin_n,
    output logic [2*NPAIR-1:0]  hiz_en,
    output logic                irq
);
    localparam int NPIN = 2 * NPAIR;

    logic      pin_s, pin_req, short_hit;
    logic      cmp_en, irq_en, short_q, dis_q;
    pin_mode_e mode;

    og_sync2 #(.W(1), .RST_VAL(1'b1)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(dis_pin_n), .q(pin_s)
    );

    og_pin_filter #(.NSAMP(NSAMP)) u_filter (
        .clk(clk), .rst_n(rst_n), .mode(mode), .pin_s(pin_s), .req(pin_req)
    );

    og_short_det #(.NPAIR(NPAIR)) u_det (
        .phase(phase_in), .en(cmp_en), .hit(short_hit)
    );

    og_ctrl_regs u_regs (
        .clk(clk), .rst_n(rst_n), .wr(reg_wr), .rd(reg_rd), .wdata(reg_wdata),
        .short_hit(short_hit), .pin_req(pin_req), .rdata(reg_rdata),
        .mode(mode), .cmp_en(cmp_en), .irq_en(irq_en),
        .short_q(short_q), .dis_q(dis_q)
    );

    assign hiz_en = {NPIN{short_q | dis_q}};
    assign irq    = irq_en & short_q;

    // R7: a raised short flag forces every pin to high impedance on the next clock
    a_r7_hiz_after_short: assert property (@(posedge clk) disable iff (!rst_n)
        short_hit |=> &hiz_en);
endmodule

// File: tb/tb_outguard_ctl.sv
module tb_outguard_ctl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic [5:0]  phase_in = 6'b010101;
    logic        dis_pin_n = 1'b1;
    logic [5:0]  hiz_en;
    logic        irq;

    int n_chk = 0, n_fail = 0, cyc = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    outguard_ctl dut (.*);

    // behavioural reference model
    bit m_valid = 0;
    bit m_short, m_dis, m_cmp, m_ien, m_arm_s, m_arm_d;
    bit [1:0] m_mode;
    bit m_s1, m_s2, m_prev;
    int m_pre, m_cnt;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_short = 0; m_dis = 0; m_cmp = 0; m_ien = 0; m_arm_s = 0; m_arm_d = 0;
            m_mode = 0; m_s1 = 1; m_s2 = 1; m_prev = 1; m_pre = 0; m_cnt = 0;
            m_valid = 1;
        end else begin
            bit req, tick, set, cs, cd, ns, nd;
            int per;
            per = (m_mode == 1) ? 8 : (m_mode == 2) ? 16 : 128;
            tick = (m_pre % per) == per - 1;
            req = 0;
            if (m_mode == 0) begin
                req = m_prev && !m_s2;
                m_cnt = 0;
            end else if (tick) begin
                if (!m_s2) begin
                    if (m_cnt < 16) begin
                        m_cnt++;
                        if (m_cnt == 16) req = 1;
                    end
                end else m_cnt = 0;
            end
            set = 0;
            for (int k = 0; k < 3; k++)
                if (!phase_in[2*k] && !phase_in[2*k+1]) set = m_cmp;
            cs = reg_wr && m_arm_s && !reg_wdata[15];
            cd = reg_wr && m_arm_d && !reg_wdata[7];
            ns = set || (m_short && !cs);
            nd = req || (m_dis && !cd);
            if (reg_wr) begin
                m_arm_s = 0; m_arm_d = 0;
                m_mode = reg_wdata[1:0]; m_cmp = reg_wdata[9]; m_ien = reg_wdata[8];
            end else if (reg_rd) begin
                if (m_short) m_arm_s = 1;
                if (m_dis) m_arm_d = 1;
            end
            m_short = ns; m_dis = nd;
            m_prev = m_s2; m_s2 = m_s1; m_s1 = dis_pin_n;
            m_pre = (m_pre + 1) % 128;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at cycle %0d", req, act, exp, cyc);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        cyc++;
        if (m_valid && rst_n) begin
            logic [15:0] er;
            er = {m_short, 5'b0, m_cmp, m_ien, m_dis, 5'b0, m_mode};
            check("R2 short bit", reg_rdata[15], er[15]);
            check("R9 disable bit", reg_rdata[7], er[7]);
            check("R6 register image", reg_rdata, er);
            check("R7 hiz", hiz_en, {6{m_short | m_dis}});
            check("R8 irq", irq, m_ien & m_short);
        end
    end

    task automatic wr(input logic [15:0] v);
        @(negedge clk); reg_wr = 1; reg_wdata = v;
        @(negedge clk); reg_wr = 0; reg_wdata = '0;
    endtask

    task automatic rd();
        @(negedge clk); reg_rd = 1;
        @(negedge clk); reg_rd = 0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic pin_low(input int n);
        @(negedge clk); dis_pin_n = 0;
        idle(n - 1);
        @(negedge clk); dis_pin_n = 1;
    endtask

    task automatic sampled_mode(input logic [15:0] w, input int per, input string tag);
        wr(w);
        pin_low(15 * per);
        idle(2 * per + 4);
        check({tag, " 15 samples no set"}, reg_rdata[7], 1'b0);
        pin_low(10 * per);
        idle(2 * per + 4);
        check({tag, " restart after high"}, reg_rdata[7], 1'b0);
        pin_low(17 * per);
        idle(4);
        check({tag, " 16 samples set"}, reg_rdata[7], 1'b1);
        idle(2 * per);
        rd(); wr(w);
        check({tag, " cleared"}, reg_rdata[7], 1'b0);
    endtask

    initial begin
        idle(3);
        check("R1 rdata", reg_rdata, 16'h0);
        check("R1 hiz", hiz_en, 6'h0);
        check("R1 irq", irq, 1'b0);
        @(negedge clk); rst_n = 1;
        idle(2);

        // R2, R7, R8
        wr(16'h0300);
        check("R6 enables readback", reg_rdata, 16'h0300);
        @(negedge clk); phase_in = 6'b010001;
        @(negedge clk);
        check("R2 set on pair1", reg_rdata[15], 1'b1);
        check("R7 hiz on short", hiz_en, 6'h3F);
        check("R8 irq on short", irq, 1'b1);
        phase_in = 6'b010101;

        // R4
        wr(16'h0300);
        check("R4 write0 without read", reg_rdata[15], 1'b1);
        rd(); wr(16'h8300);
        check("R4 write1 no effect", reg_rdata[15], 1'b1);
        rd(); wr(16'h0300);
        check("R4 cleared", reg_rdata[15], 1'b0);
        check("R7 hiz released", hiz_en, 6'h0);

        // R5
        @(negedge clk); phase_in = 6'b010100;
        rd(); wr(16'h0300);
        check("R5 set wins", reg_rdata[15], 1'b1);
        @(negedge clk); phase_in = 6'b010101;
        rd(); wr(16'h0100);
        check("R5 later clear", reg_rdata[15], 1'b0);

        // R3
        @(negedge clk); phase_in = 6'b000101;
        idle(5);
        check("R3 compare off", reg_rdata[15], 1'b0);
        check("R8 no irq", irq, 1'b0);
        phase_in = 6'b010101;

        // R6
        wr(16'hFFFF);
        check("R6 reserved and flags", reg_rdata, 16'h0303);
        wr(16'h0300);

        // R9
        @(negedge clk); dis_pin_n = 0;
        @(negedge clk);
        @(negedge clk);
        check("R9 not before 3 clocks", reg_rdata[7], 1'b0);
        @(negedge clk);
        check("R9 edge sets", reg_rdata[7], 1'b1);
        check("R7 hiz on disable", hiz_en, 6'h3F);
        dis_pin_n = 1;
        idle(3);
        wr(16'h0300);
        check("R11 no clear without read", reg_rdata[7], 1'b1);
        rd(); wr(16'h0380);
        check("R11 write1 no effect", reg_rdata[7], 1'b1);
        rd(); wr(16'h0300);
        check("R11 cleared", reg_rdata[7], 1'b0);

        // R10
        sampled_mode(16'h0301, 8, "R10 div8");
        sampled_mode(16'h0302, 16, "R10 div16");
        sampled_mode(16'h0303, 128, "R10 div128");

        idle(5);
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        while (cyc < 150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule